// File: doc/BRIEF.md
# Float/Integer Conversion Unit

This block converts between IEEE-754 single-precision values and signed 32-bit two's-complement integers. The operand is 64 bits wide and holds two 32-bit lanes. A two-bit operation code selects one of three things: integer to float, float to integer using the rounding mode on the `rmode` input, or float to integer with forced rounding toward zero. A fourth code passes the operand through unchanged. The rounding mode is a run-time input, so each conversion may use a different mode.

In packed mode both lanes convert independently, and each status flag is the OR of the two lane flags. In scalar mode only the low lane converts. The upper lane is then copied to the result unchanged and has no effect on the flags. Results and flags are registered, so each accepted operation appears exactly one clock later with `out_valid`. Exception trapping, double precision, the control/status register and flush-to-zero modes are outside this block.

Top module: `fpcvt_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high and low otherwise. A synchronous reset clears `out_valid`, `result`, `inexact` and `invalid` to zero.
- R2: Operation codes: 00 integer to float, 01 float to integer with the selected mode, 10 float to integer truncating, 11 pass-through. Pass-through returns the operand unchanged with both flags low.
- R3: Integer to float reads the lane as a signed 32-bit value and returns the single-precision value rounded by the selected mode. Integer 0 gives +0.0 (0x00000000), and -2^31 gives 0xCF000000 exactly.
- R4: Rounding-mode encoding: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R5: Float to integer (code 01) returns the signed 32-bit integer rounded by the selected mode. Both +0.0 and -0.0 give 0.
- R6: The truncating code 10 always rounds toward zero and ignores `rmode`.
- R7: A float-to-integer conversion of NaN, of infinity, or of a value whose rounded result lies outside [-2^31, 2^31-1] returns 0x80000000 for that lane and raises `invalid`, with `inexact` low for that lane.
- R8: `inexact` is high when any discarded bit is nonzero. A denormal converted with truncation gives 0 with `inexact` high.
- R9: In packed mode (`packed_mode`=1) both lanes convert, and each flag is the OR of the per-lane flags.
- R10: In scalar mode (`packed_mode`=0) only bits 31:0 convert. Bits 63:32 of the result equal bits 63:32 of the operand, and that lane does not affect the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | Operation code (see R2) |
| rmode | input | 2 | Rounding mode (see R4) |
| packed_mode | input | 1 | 1 = both lanes, 0 = low lane only |
| operand | input | 64 | Two 32-bit source lanes |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Two 32-bit result lanes |
| inexact | output | 1 | Some discarded bits were nonzero |
| invalid | output | 1 | NaN, infinity or out-of-range source |

## Verification
Each state fault in this block shows up at the ports on the very next cycle, because the only state is the output register. A wrong leading-one position or a wrong shift gives a grossly wrong exponent or integer. A wrong rounding decision gives an off-by-one LSB, or a flipped `inexact`, that is visible only on tie and near-tie operands such as 0.5, 1.5 and 2^24+1. A wrong lane enable corrupts the upper lane in scalar mode, or leaks a flag from it. The directed cases therefore cover every mode at these operands, the range limits of ±2^31, and a NaN in the passive lane.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = 127;
  // exponent at which the significand LSB has weight 1
  localparam int UNIT_EXP = BIAS + FRAC_W;

  typedef enum logic [1:0] {
    OP_I2F       = 2'b00,
    OP_F2I       = 2'b01,
    OP_F2I_TRUNC = 2'b10,
    OP_PASS      = 2'b11
  } cvt_op_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              inexact;
    logic              invalid;
  } lane_res_t;

  // Decide whether the magnitude must be incremented by one unit.
  function automatic logic round_up(rmode_e rm, logic neg, logic lsb,
                                    logic guard, logic sticky);
    logic lost;
    lost = guard | sticky;
    unique case (rm)
      RM_NEAR: return guard & (sticky | lsb);
      RM_DOWN: return neg & lost;
      RM_UP:   return ~neg & lost;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpcvt_i2f.sv
module fpcvt_i2f
  import fpcvt_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  rmode_e            rm,
  output lane_res_t         res
);

  logic              neg;
  logic [WORD_W-1:0] mag;
  logic [4:0]        lead;
  logic [WORD_W-1:0] norm;
  logic              guard, sticky, inc;
  logic [30:0]       packed_mag;
  logic [30:0]       rounded;

  always_comb begin
    neg  = src[WORD_W-1];
    mag  = neg ? (~src + 1'b1) : src;
    lead = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (mag[i]) lead = 5'(i);
    end
    norm       = mag << (5'd31 - lead);
    guard      = norm[7];
    sticky     = |norm[6:0];
    packed_mag = {8'(BIAS) + {3'b000, lead}, norm[30:8]};
    inc        = round_up(rm, neg, norm[8], guard, sticky);
    rounded    = packed_mag + {30'd0, inc};
    res.value   = norm[31] ? {neg, rounded} : '0;
    res.inexact = guard | sticky;
    res.invalid = 1'b0;
  end

endmodule

// File: rtl/fpcvt_f2i.sv
module fpcvt_f2i
  import fpcvt_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  rmode_e            rm,
  output lane_res_t         res
);

  logic             neg;
  logic [EXP_W-1:0] exp_raw, exp_eff, rsh;
  logic [SIG_W-1:0] sig;
  logic             special, big, left_case;
  logic [WORD_W-1:0] int_part;
  logic [55:0]      ext;
  logic             guard, sticky, inc, ovf, bad;
  logic [WORD_W:0]  rounded;

  always_comb begin
    neg       = src[WORD_W-1];
    exp_raw   = src[30:23];
    exp_eff   = (exp_raw == '0) ? 8'd1 : exp_raw;
    sig       = {|exp_raw, src[FRAC_W-1:0]};
    special   = &exp_raw;
    big       = exp_eff >= 8'(UNIT_EXP + 8);
    left_case = exp_eff >= 8'(UNIT_EXP);
    rsh       = 8'(UNIT_EXP) - exp_eff;
    int_part  = '0;
    guard     = 1'b0;
    sticky    = 1'b0;
    ext       = '0;
    if (big) begin
      int_part = 32'h8000_0000;
    end else if (left_case) begin
      int_part = {8'd0, sig} << (exp_eff[2:0] - 3'd6);
    end else if (rsh >= 8'd25) begin
      sticky = |sig;
    end else begin
      ext      = {sig, 32'd0} >> rsh[4:0];
      int_part = {8'd0, ext[55:32]};
      guard    = ext[31];
      sticky   = |ext[30:0];
    end
    inc     = round_up(rm, neg, int_part[0], guard, sticky);
    rounded = {1'b0, int_part} + {32'd0, inc};
    if (big)
      ovf = ~(neg && exp_eff == 8'(UNIT_EXP + 8) && src[FRAC_W-1:0] == '0);
    else if (neg)
      ovf = rounded > 33'h0_8000_0000;
    else
      ovf = rounded > 33'h0_7FFF_FFFF;
    bad         = special | ovf;
    res.value   = bad ? 32'h8000_0000
                      : (neg ? (~rounded[31:0] + 1'b1) : rounded[31:0]);
    res.inexact = (guard | sticky) & ~bad;
    res.invalid = bad;
  end

endmodule

// File: rtl/fpcvt_lane.sv
module fpcvt_lane
  import fpcvt_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  cvt_op_e           op,
  input  rmode_e            rm,
  input  logic              enable,
  output lane_res_t         res
);

  lane_res_t i2f_res, f2i_res;
  rmode_e    f2i_rm;

  assign f2i_rm = (op == OP_F2I_TRUNC) ? RM_ZERO : rm;

  fpcvt_i2f u_i2f (.src(src), .rm(rm),     .res(i2f_res));
  fpcvt_f2i u_f2i (.src(src), .rm(f2i_rm), .res(f2i_res));

  always_comb begin
    res = '{value: src, inexact: 1'b0, invalid: 1'b0};
    if (enable) begin
      unique case (op)
        OP_I2F:                 res = i2f_res;
        OP_F2I, OP_F2I_TRUNC:   res = f2i_res;
        default:                res = '{value: src, inexact: 1'b0, invalid: 1'b0};
      endcase
    end
  end

endmodule

// File: rtl/fpcvt_unit.sv
module fpcvt_unit
  import fpcvt_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              op,
  input  logic [1:0]              rmode,
  input  logic                    packed_mode,
  input  logic [LANES*WORD_W-1:0] operand,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] result,
  output logic                    inexact,
  output logic                    invalid
);

  localparam int TOTAL_W = LANES * WORD_W;

  lane_res_t         lane_res [LANES];
  logic [TOTAL_W-1:0] next_result;
  logic               next_inexact, next_invalid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_en;
    if (l == 0) begin : g_low
      assign lane_en = 1'b1;
    end else begin : g_high
      assign lane_en = packed_mode;
    end
    fpcvt_lane u_lane (
      .src    (operand[l*WORD_W +: WORD_W]),
      .op     (cvt_op_e'(op)),
      .rm     (rmode_e'(rmode)),
      .enable (lane_en),
      .res    (lane_res[l])
    );
  end

  always_comb begin
    next_inexact = 1'b0;
    next_invalid = 1'b0;
    next_result  = '0;
    for (int l = 0; l < LANES; l++) begin
      next_result[l*WORD_W +: WORD_W] = lane_res[l].value;
      next_inexact = next_inexact | lane_res[l].inexact;
      next_invalid = next_invalid | lane_res[l].invalid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_result;
        inexact <= next_inexact;
        invalid <= next_invalid;
      end
    end
  end

endmodule

// File: rtl/fpcvt_unit_chk.sv
module fpcvt_unit_chk #(
  parameter int LANES = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [1:0]            op,
  input logic                  packed_mode,
  input logic [LANES*32-1:0]   operand,
  input logic                  out_valid,
  input logic [LANES*32-1:0]   result,
  input logic                  inexact,
  input logic                  invalid
);

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> (result == $past(operand) && !inexact && !invalid));

  // R3
  i2f_never_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> !invalid);

  // R7
  invalid_code_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && invalid) |->
      (result[31:0] == 32'h8000_0000 || result[LANES*32-1 -: 32] == 32'h8000_0000));

  // R10
  scalar_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !packed_mode) |=>
      (result[LANES*32-1:32] == $past(operand[LANES*32-1:32])));

endmodule

bind fpcvt_unit fpcvt_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .packed_mode(packed_mode), .operand(operand), .out_valid(out_valid),
  .result(result), .inexact(inexact), .invalid(invalid)
);

// File: tb/tb_fpcvt_unit.sv
`timescale 1ns/1ps
module tb_fpcvt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [1:0]  rmode = 2'b00;
  logic        packed_mode = 1'b0;
  logic [63:0] operand = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        inexact, invalid;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [1:0] I2F = 2'b00, F2I = 2'b01, TRN = 2'b10, PAS = 2'b11;
  localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, TZ = 2'b11;
  localparam logic [31:0] HI_FILL = 32'hDEAD_BEEF;

  always #4 clk = ~clk;

  fpcvt_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rmode(rmode),
    .packed_mode(packed_mode), .operand(operand), .out_valid(out_valid),
    .result(result), .inexact(inexact), .invalid(invalid)
  );

  task automatic check(string req, logic [65:0] act, logic [65:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run(string req, logic [1:0] o, logic [1:0] rm, logic pk,
                     logic [63:0] opnd, logic [63:0] exp_res,
                     logic exp_inx, logic exp_inv);
    @(negedge clk);
    op = o; rmode = rm; packed_mode = pk; operand = opnd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, result, inexact}, {1'b1, exp_res, exp_inx});
    check(req, {65'd0, invalid}, {65'd0, exp_inv});
  endtask

  task automatic scalar(string req, logic [1:0] o, logic [1:0] rm,
                        logic [31:0] a, logic [31:0] e, logic inx, logic inv);
    run(req, o, rm, 1'b0, {HI_FILL, a}, {HI_FILL, e}, inx, inv);
  endtask

  task automatic t_reset();
    // R1
    check("R1 reset", {out_valid, result, inexact}, 66'd0);
    check("R1 reset", {65'd0, invalid}, 66'd0);
  endtask

  task automatic t_int_to_float();
    scalar("R3 zero",       I2F, NE, 32'h0000_0000, 32'h0000_0000, 0, 0);
    scalar("R3 one",        I2F, NE, 32'h0000_0001, 32'h3F80_0000, 0, 0);
    scalar("R3 minus one",  I2F, NE, 32'hFFFF_FFFF, 32'hBF80_0000, 0, 0);
    scalar("R3 min int",    I2F, NE, 32'h8000_0000, 32'hCF00_0000, 0, 0);
    // R4 each mode on 2^31-1
    scalar("R4 max near",   I2F, NE, 32'h7FFF_FFFF, 32'h4F00_0000, 1, 0);
    scalar("R4 max down",   I2F, DN, 32'h7FFF_FFFF, 32'h4EFF_FFFF, 1, 0);
    scalar("R4 max up",     I2F, UP, 32'h7FFF_FFFF, 32'h4F00_0000, 1, 0);
    scalar("R4 max zero",   I2F, TZ, 32'h7FFF_FFFF, 32'h4EFF_FFFF, 1, 0);
    scalar("R8 tie even",   I2F, NE, 32'h0100_0001, 32'h4B80_0000, 1, 0);
    scalar("R4 tie up",     I2F, UP, 32'h0100_0001, 32'h4B80_0001, 1, 0);
    scalar("R4 neg down",   I2F, DN, 32'hFEFF_FFFF, 32'hCB80_0001, 1, 0);
    scalar("R4 neg up",     I2F, UP, 32'hFEFF_FFFF, 32'hCB80_0000, 1, 0);
  endtask

  task automatic t_float_to_int();
    scalar("R5 1.5 near",   F2I, NE, 32'h3FC0_0000, 32'd2, 1, 0);
    scalar("R5 1.5 down",   F2I, DN, 32'h3FC0_0000, 32'd1, 1, 0);
    scalar("R5 1.5 up",     F2I, UP, 32'h3FC0_0000, 32'd2, 1, 0);
    scalar("R5 1.5 zero",   F2I, TZ, 32'h3FC0_0000, 32'd1, 1, 0);
    scalar("R5 0.5 near",   F2I, NE, 32'h3F00_0000, 32'd0, 1, 0);
    scalar("R5 0.5 up",     F2I, UP, 32'h3F00_0000, 32'd1, 1, 0);
    scalar("R5 2.5 near",   F2I, NE, 32'h4020_0000, 32'd2, 1, 0);
    scalar("R5 -1.5 near",  F2I, NE, 32'hBFC0_0000, 32'hFFFF_FFFE, 1, 0);
    scalar("R5 -1.5 up",    F2I, UP, 32'hBFC0_0000, 32'hFFFF_FFFF, 1, 0);
    scalar("R5 neg zero",   F2I, NE, 32'h8000_0000, 32'd0, 0, 0);
    scalar("R5 top exact",  F2I, NE, 32'h4EFF_FFFF, 32'h7FFF_FF80, 0, 0);
    scalar("R7 min exact",  F2I, NE, 32'hCF00_0000, 32'h8000_0000, 0, 0);
  endtask

  task automatic t_truncate();
    scalar("R6 1.5 mode near", TRN, NE, 32'h3FC0_0000, 32'd1, 1, 0);
    scalar("R6 1.5 mode up",   TRN, UP, 32'h3FC0_0000, 32'd1, 1, 0);
    scalar("R6 -1.5 mode dn",  TRN, DN, 32'hBFC0_0000, 32'hFFFF_FFFF, 1, 0);
    scalar("R8 denorm trunc",  TRN, UP, 32'h0000_0001, 32'd0, 1, 0);
    scalar("R8 denorm up",     F2I, UP, 32'h0000_0001, 32'd1, 1, 0);
    scalar("R8 neg denorm dn", F2I, DN, 32'h8000_0001, 32'hFFFF_FFFF, 1, 0);
  endtask

  task automatic t_invalid();
    scalar("R7 2^31",  F2I, NE, 32'h4F00_0000, 32'h8000_0000, 0, 1);
    scalar("R7 nan",   F2I, NE, 32'h7FC0_0000, 32'h8000_0000, 0, 1);
    scalar("R7 inf",   TRN, NE, 32'h7F80_0000, 32'h8000_0000, 0, 1);
    scalar("R7 -inf",  F2I, DN, 32'hFF80_0000, 32'h8000_0000, 0, 1);
  endtask

  task automatic t_lanes();
    run("R9 packed i2f", I2F, NE, 1'b1, {32'h0000_0002, 32'h7FFF_FFFF},
        {32'h4000_0000, 32'h4F00_0000}, 1, 0);
    run("R9 packed f2i", F2I, NE, 1'b1, {32'h7F80_0000, 32'h3F80_0000},
        {32'h8000_0000, 32'h0000_0001}, 0, 1);
    run("R9 packed hi inexact", F2I, TZ, 1'b1, {32'h3FC0_0000, 32'h4000_0000},
        {32'h0000_0001, 32'h0000_0002}, 1, 0);
    run("R10 scalar hi nan", F2I, NE, 1'b0, {32'h7FC0_0000, 32'h4000_0000},
        {32'h7FC0_0000, 32'h0000_0002}, 0, 0);
    run("R2 pass", PAS, UP, 1'b1, 64'h7FC0_0000_3FC0_0000,
        64'h7FC0_0000_3FC0_0000, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    // R1
    check("R1 idle", {65'd0, out_valid}, 66'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_int_to_float();
    t_float_to_int();
    t_truncate();
    t_invalid();
    t_lanes();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule